// File: doc/BRIEF.md
# Operator Console Command Interpreter

This block sits between an operator console character link and the control lines of a small computer system. It collects the characters the operator types. When a carriage return (0x0D) arrives it decodes the line as one control command. If the front-panel functions switch and the system idle status allow the command, the block acts on it: it raises an interrupt request, reads or writes the 4-bit sense-switch register, starts a load, or pulses the system, processor or I/O reset, the halt or the run line. It then streams a formatted ASCII echo back toward the console, one byte per accepted handshake.

Every command begins with the letters `Z` and `C`. A mnemonic follows: `I`, `SSW`, `SS` plus one hex digit, `LDN` plus four hex digits, `RSY`, `RBP`, `RIO`, `HLT` or `RUN`. A line that cannot be decoded, or that its gating refuses, produces the echo `(ERR)` and leaves every register and output untouched. The load address and a start pulse go to a separate load sequencer. The interrupt request goes to the controller of interrupt level 0x5D, whose current state is reported back to this block.

Top module: `opcon_cmd`

## Requirements
- R1: A character is taken when `rx_valid` and `rx_ready` are both high. `rx_ready` is low from the cycle after a carriage return until the last echo byte is taken. Echo bytes leave on `tx_valid`/`tx_ready`, and `tx_data` does not change while `tx_valid` is high and `tx_ready` is low.
- R2: `RSY`, `RBP`, `RIO`, `HLT`, `RUN` and `LDN` are refused with `(ERR)` when `fn_enable` is low. `I`, `SSW` and `SS#` ignore `fn_enable` and `sys_idle`.
- R3: `RSY`, `RBP`, `RIO`, `RUN` and `LDN` are refused with `(ERR)` when `sys_idle` is low. `HLT` does not depend on `sys_idle`.
- R4: `ZCSS` followed by an uppercase hex digit (0-9, A-F) loads that value into `sense_sw` and echoes `(SS` + digit + `=` + four binary digits, most significant bit first, + `)`. For example `ZCSS3` gives `(SS3=0011)`.
- R5: `ZCSSW` echoes `(SSW=` + `sense_sw` as four binary digits, most significant bit first, + `)`.
- R6: `ZCI` always echoes `(I)`. The `lvl_state` encoding is 00 disarmed, 01 armed, 10 waiting and 11 active. `irq_set` pulses for one cycle only when `lvl_state` is 01 at the carriage return.
- R7: For a set command, `cpu_hold` is high for exactly two cycles, starting the cycle after the carriage return, and the new value appears when it falls. A `cpu_sw_we` write is dropped while `cpu_hold` is high and otherwise loads `cpu_sw_wdata` on the next edge.
- R8: `rst_n` and `super_reset` clear `sense_sw` to 0. `super_reset` takes priority over both writers.
- R9: `ZCLDN` followed by four uppercase hex digits loads `load_addr` and pulses `load_start` for one cycle. It echoes `(LDN@` + the four digits + `)`.
- R10: An accepted `RSY`, `RBP`, `RIO`, `HLT` or `RUN` pulses `rst_sys`, `rst_cpu`, `rst_io`, `halt_pulse` or `run_pulse` respectively for exactly one cycle. The pulse occurs in the cycle after the carriage return, and the echo is `(` + mnemonic + `)`.
- R11: A wrong prefix, an unknown mnemonic, a wrong length, a bad hex digit, a line longer than nine characters, an empty line or a gating refusal echoes `(ERR)`. Such a line pulses nothing and changes neither `sense_sw` nor `load_addr`.
- R12: After reset, `rx_ready` is 1, and `tx_valid`, `cpu_hold`, every pulse, `sense_sw` and `load_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Console character present |
| rx_data | input | 8 | Console character (ASCII) |
| rx_ready | output | 1 | Block can take a character |
| tx_valid | output | 1 | Echo byte present |
| tx_data | output | 8 | Echo byte (ASCII) |
| tx_ready | input | 1 | Console takes the echo byte |
| fn_enable | input | 1 | Panel functions switch in enable position |
| sys_idle | input | 1 | System is in the idle state |
| lvl_state | input | 2 | State of interrupt level 0x5D |
| irq_set | output | 1 | Pulse: advance level 0x5D from armed to waiting |
| super_reset | input | 1 | Clears the sense switches |
| cpu_sw_we | input | 1 | Processor write strobe for the sense switches |
| cpu_sw_wdata | input | 4 | Processor write value |
| cpu_hold | output | 1 | Holds the processor idle during a console write |
| sense_sw | output | 4 | Sense-switch register |
| rst_sys | output | 1 | System reset pulse |
| rst_cpu | output | 1 | Processor reset pulse |
| rst_io | output | 1 | I/O reset pulse |
| halt_pulse | output | 1 | Halt pulse |
| run_pulse | output | 1 | Run pulse |
| load_start | output | 1 | Start pulse to the load sequencer |
| load_addr | output | 16 | Load device address |

## Verification
The bench issues a processor write inside the two-cycle hold window and samples `sense_sw` mid-window. A design that let the processor through would show the processor value there or lose the console value. It holds `tx_ready` low on the first echo byte, which exposes an echo pointer that advances without a handshake. It runs the gating matrix across both panel inputs, including `HLT` with the system busy, where a design that tied halt to idle would refuse it. It also sends malformed lines: a bad hex digit, an overlong load line, an empty line and a wrong prefix. A design that acted on part of such a line would change `sense_sw`, move `load_addr` or emit a pulse.

// File: rtl/opcon_cmd.sv
module opcon_cmd #(
  parameter int         MAX_CHARS = 9,
  parameter int         ECHO_MAX  = 10,
  parameter logic [7:0] EOL       = 8'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        fn_enable,
  input  logic        sys_idle,
  input  logic [1:0]  lvl_state,
  output logic        irq_set,
  input  logic        super_reset,
  input  logic        cpu_sw_we,
  input  logic [3:0]  cpu_sw_wdata,
  output logic        cpu_hold,
  output logic [3:0]  sense_sw,
  output logic        rst_sys,
  output logic        rst_cpu,
  output logic        rst_io,
  output logic        halt_pulse,
  output logic        run_pulse,
  output logic        load_start,
  output logic [15:0] load_addr
);
  localparam int CW = $clog2(MAX_CHARS + 1);
  localparam int EW = $clog2(ECHO_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_CHARS);

  typedef enum logic [1:0] {ST_COLLECT, ST_HOLD, ST_WRITE, ST_ECHO} st_t;
  typedef enum logic [3:0] {C_NONE, C_INT, C_SSW, C_SS, C_LDN,
                            C_RSY, C_RBP, C_RIO, C_HLT, C_RUN} cmd_t;

  st_t           st;
  logic [7:0]    cb [MAX_CHARS];
  logic [CW-1:0] clen;
  logic          ovf;
  logic [7:0]    eb [ECHO_MAX];
  logic [EW-1:0] elen, eidx;
  logic [3:0]    ss_new;

  cmd_t          cmd;
  logic          ok, need_en, need_idle;
  logic [7:0]    en [ECHO_MAX];
  logic [EW-1:0] en_len;
  logic [3:0]    bits;
  logic [23:0]   mn;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    return (c <= 8'h39) ? c[3:0] : c[3:0] + 4'd9;
  endfunction

  function automatic logic [7:0] bchr(input logic b);
    return b ? 8'h31 : 8'h30;
  endfunction

  wire take = rx_valid && rx_ready;
  wire eol  = take && (rx_data == EOL);

  assign rx_ready = (st == ST_COLLECT);
  assign cpu_hold = (st == ST_HOLD) || (st == ST_WRITE);
  assign tx_valid = (st == ST_ECHO);
  assign tx_data  = eb[eidx];
  assign mn       = {cb[2], cb[3], cb[4]};

  always_comb begin
    cmd = C_NONE;
    if (!ovf && cb[0] == "Z" && cb[1] == "C") begin
      if (clen == CW'(3) && cb[2] == "I")
        cmd = C_INT;
      else if (clen == CW'(5)) begin
        case (mn)
          "SSW":   cmd = C_SSW;
          "RSY":   cmd = C_RSY;
          "RBP":   cmd = C_RBP;
          "RIO":   cmd = C_RIO;
          "HLT":   cmd = C_HLT;
          "RUN":   cmd = C_RUN;
          default: if (cb[2] == "S" && cb[3] == "S" && is_hex(cb[4])) cmd = C_SS;
        endcase
      end else if (clen == CW'(9) && mn == "LDN" &&
                   is_hex(cb[5]) && is_hex(cb[6]) && is_hex(cb[7]) && is_hex(cb[8]))
        cmd = C_LDN;
    end
  end

  always_comb begin
    need_en   = cmd inside {C_LDN, C_RSY, C_RBP, C_RIO, C_HLT, C_RUN};
    need_idle = cmd inside {C_LDN, C_RSY, C_RBP, C_RIO, C_RUN};
    ok = (cmd != C_NONE) && (!need_en || fn_enable) && (!need_idle || sys_idle);
  end

  always_comb begin
    for (int i = 0; i < ECHO_MAX; i++) en[i] = 8'h20;
    en[0]  = "(";
    en_len = EW'(5);
    bits   = (cmd == C_SSW) ? sense_sw : hex_val(cb[4]);
    if (!ok) begin
      en[1] = "E"; en[2] = "R"; en[3] = "R"; en[4] = ")";
    end else begin
      case (cmd)
        C_INT: begin
          en[1] = "I"; en[2] = ")"; en_len = EW'(3);
        end
        C_SSW, C_SS: begin
          en[1] = "S"; en[2] = "S";
          en[3] = (cmd == C_SSW) ? 8'h57 : cb[4];
          en[4] = "=";
          en[5] = bchr(bits[3]); en[6] = bchr(bits[2]);
          en[7] = bchr(bits[1]); en[8] = bchr(bits[0]);
          en[9] = ")"; en_len = EW'(10);
        end
        C_LDN: begin
          en[1] = cb[2]; en[2] = cb[3]; en[3] = cb[4]; en[4] = "@";
          en[5] = cb[5]; en[6] = cb[6]; en[7] = cb[7]; en[8] = cb[8];
          en[9] = ")"; en_len = EW'(10);
        end
        default: begin
          en[1] = cb[2]; en[2] = cb[3]; en[3] = cb[4]; en[4] = ")";
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_COLLECT && take && !eol && clen != CMAX) cb[clen] <= rx_data;
    if (st == ST_COLLECT && eol)
      for (int i = 0; i < ECHO_MAX; i++) eb[i] <= en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_COLLECT;
      clen       <= '0;
      ovf        <= 1'b0;
      elen       <= '0;
      eidx       <= '0;
      ss_new     <= '0;
      load_addr  <= '0;
      irq_set    <= 1'b0;
      rst_sys    <= 1'b0;
      rst_cpu    <= 1'b0;
      rst_io     <= 1'b0;
      halt_pulse <= 1'b0;
      run_pulse  <= 1'b0;
      load_start <= 1'b0;
    end else begin
      irq_set    <= 1'b0;
      rst_sys    <= 1'b0;
      rst_cpu    <= 1'b0;
      rst_io     <= 1'b0;
      halt_pulse <= 1'b0;
      run_pulse  <= 1'b0;
      load_start <= 1'b0;
      case (st)
        ST_COLLECT: begin
          if (eol) begin
            elen <= en_len;
            eidx <= '0;
            clen <= '0;
            ovf  <= 1'b0;
            if (ok) begin
              case (cmd)
                C_INT: irq_set <= (lvl_state == 2'b01);
                C_SS:  ss_new  <= hex_val(cb[4]);
                C_LDN: begin
                  load_addr  <= {hex_val(cb[5]), hex_val(cb[6]), hex_val(cb[7]), hex_val(cb[8])};
                  load_start <= 1'b1;
                end
                C_RSY: rst_sys    <= 1'b1;
                C_RBP: rst_cpu    <= 1'b1;
                C_RIO: rst_io     <= 1'b1;
                C_HLT: halt_pulse <= 1'b1;
                C_RUN: run_pulse  <= 1'b1;
                default: ;
              endcase
            end
            st <= (ok && cmd == C_SS) ? ST_HOLD : ST_ECHO;
          end else if (take) begin
            if (clen == CMAX) ovf <= 1'b1;
            else clen <= clen + 1'b1;
          end
        end
        ST_HOLD:  st <= ST_WRITE;
        ST_WRITE: st <= ST_ECHO;
        ST_ECHO: begin
          if (tx_ready) begin
            eidx <= eidx + 1'b1;
            if (eidx == elen - 1'b1) st <= ST_COLLECT;
          end
        end
        default: st <= ST_COLLECT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sense_sw <= '0;
    else if (super_reset)            sense_sw <= '0;
    else if (st == ST_WRITE)         sense_sw <= ss_new;
    else if (cpu_sw_we && !cpu_hold) sense_sw <= cpu_sw_wdata;
  end

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sys || rst_cpu || rst_io || halt_pulse || run_pulse || load_start) |-> $past(fn_enable)); // R2
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sys || rst_cpu || rst_io || run_pulse || load_start) |-> $past(sys_idle)); // R3
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_set, rst_sys, rst_cpu, rst_io, halt_pulse, run_pulse, load_start})); // R10
  AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> ($past(lvl_state) == 2'b01)); // R6
  AST_HOLD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |=> cpu_hold); // R7
  AST_SRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(super_reset) |-> (sense_sw == 4'h0)); // R8
  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R1
endmodule

// File: tb/opcon_cmd_test.sv
module opcon_cmd_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic fn_enable = 1'b0, sys_idle = 1'b0;
  logic [1:0] lvl_state = 2'b00;
  logic irq_set, cpu_hold;
  logic super_reset = 1'b0, cpu_sw_we = 1'b0;
  logic [3:0] cpu_sw_wdata = 4'h0, sense_sw;
  logic rst_sys, rst_cpu, rst_io, halt_pulse, run_pulse, load_start;
  logic [15:0] load_addr;

  int tests = 0, fails = 0;
  bit done = 0;
  int cnt [8];
  int base [8];
  logic [7:0] ebuf [256];
  int etotal = 0;
  int estart = 0;

  always #2.5 clk = ~clk;

  opcon_cmd uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .fn_enable(fn_enable), .sys_idle(sys_idle), .lvl_state(lvl_state), .irq_set(irq_set),
    .super_reset(super_reset), .cpu_sw_we(cpu_sw_we), .cpu_sw_wdata(cpu_sw_wdata),
    .cpu_hold(cpu_hold), .sense_sw(sense_sw), .rst_sys(rst_sys), .rst_cpu(rst_cpu),
    .rst_io(rst_io), .halt_pulse(halt_pulse), .run_pulse(run_pulse),
    .load_start(load_start), .load_addr(load_addr));

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      ebuf[etotal % 256] <= tx_data;
      etotal <= etotal + 1;
    end
    if (irq_set)    cnt[0] <= cnt[0] + 1;
    if (rst_sys)    cnt[1] <= cnt[1] + 1;
    if (rst_cpu)    cnt[2] <= cnt[2] + 1;
    if (rst_io)     cnt[3] <= cnt[3] + 1;
    if (halt_pulse) cnt[4] <= cnt[4] + 1;
    if (run_pulse)  cnt[5] <= cnt[5] + 1;
    if (load_start) cnt[6] <= cnt[6] + 1;
    if (cpu_hold)   cnt[7] <= cnt[7] + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_echo(input string req, input string exp);
    bit bad;
    int n;
    n = etotal - estart;
    bad = (n != exp.len());
    for (int i = 0; i < exp.len() && !bad; i++)
      if (ebuf[(estart + i) % 256] != exp[i]) bad = 1;
    tests++;
    if (bad) begin
      fails++;
      $write("FAIL %s echo: got \"", req);
      for (int i = 0; i < n && i < 32; i++) $write("%c", ebuf[(estart + i) % 256]);
      $display("\" expected \"%s\"", exp);
    end
  endtask

  task automatic chk_pulses(input string req, input logic [6:0] mask, input int hold_exp);
    for (int i = 0; i < 7; i++)
      chk(req, $sformatf("pulse count %0d", i), cnt[i] - base[i], {31'd0, mask[i]});
    chk(req, "hold cycles", cnt[7] - base[7], hold_exp);
  endtask

  task automatic put(input logic [7:0] c);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic begin_cmd(input string s);
    @(negedge clk);
    for (int i = 0; i < 8; i++) base[i] = cnt[i];
    estart = etotal;
    for (int i = 0; i < s.len(); i++) put(s[i]);
    put(8'h0D);
  endtask

  task automatic end_cmd;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input string s);
    begin_cmd(s);
    end_cmd();
  endtask

  task automatic t_reset;
    chk("R12", "rx_ready", rx_ready, 1);
    chk("R12", "tx_valid", tx_valid, 0);
    chk("R12", "cpu_hold", cpu_hold, 0);
    chk("R12", "pulses", {irq_set, rst_sys, rst_cpu, rst_io, halt_pulse, run_pulse, load_start}, 0);
    chk("R12", "sense_sw", sense_sw, 0);
    chk("R12", "load_addr", load_addr, 0);
  endtask

  task automatic t_set_switches;
    fn_enable = 0; sys_idle = 0;
    run_cmd("ZCSS3");
    chk_echo("R4", "(SS3=0011)");
    chk("R4", "sense after SS3", sense_sw, 4'h3);
    chk_pulses("R7", 7'h00, 2);
    run_cmd("ZCSSA");
    chk_echo("R4", "(SSA=1010)");
    chk("R4", "sense after SSA", sense_sw, 4'hA);
  endtask

  task automatic t_read_backpressure;
    tx_ready = 0;
    begin_cmd("ZCSSW");
    for (int i = 0; i < 3; i++) begin
      chk("R1", "tx_valid held", tx_valid, 1);
      chk("R1", "tx_data held", tx_data, 8'h28);
      chk("R1", "rx_ready low", rx_ready, 0);
      @(negedge clk);
    end
    tx_ready = 1;
    end_cmd();
    chk_echo("R5", "(SSW=1010)");
    chk("R5", "sense unchanged", sense_sw, 4'hA);
  endtask

  task automatic t_cpu_arbitration;
    @(negedge clk);
    cpu_sw_we = 1; cpu_sw_wdata = 4'h6;
    @(negedge clk);
    cpu_sw_we = 0;
    chk("R7", "free cpu write", sense_sw, 4'h6);
    begin_cmd("ZCSS9");
    chk("R7", "hold raised", cpu_hold, 1);
    cpu_sw_we = 1; cpu_sw_wdata = 4'hF;
    @(negedge clk);
    chk("R7", "cpu write blocked mid-hold", sense_sw, 4'h6);
    chk("R7", "hold second cycle", cpu_hold, 1);
    @(negedge clk);
    cpu_sw_we = 0;
    chk("R7", "hold released", cpu_hold, 0);
    chk("R7", "console value after hold", sense_sw, 4'h9);
    end_cmd();
    chk_echo("R4", "(SS9=1001)");
  endtask

  task automatic t_interrupt;
    fn_enable = 0; sys_idle = 0;
    for (int s = 0; s < 4; s++) begin
      lvl_state = 2'(s);
      run_cmd("ZCI");
      chk_echo("R6", "(I)");
      chk_pulses("R6", (s == 1) ? 7'h01 : 7'h00, 0);
    end
    lvl_state = 2'b00;
  endtask

  task automatic t_gating;
    fn_enable = 0; sys_idle = 1;
    run_cmd("ZCRSY");
    chk_echo("R2", "(ERR)");
    chk_pulses("R2", 7'h00, 0);
    run_cmd("ZCHLT");
    chk_echo("R2", "(ERR)");
    chk_pulses("R2", 7'h00, 0);
    fn_enable = 1; sys_idle = 0;
    run_cmd("ZCRUN");
    chk_echo("R3", "(ERR)");
    chk_pulses("R3", 7'h00, 0);
    run_cmd("ZCLDN00AB");
    chk_echo("R3", "(ERR)");
    chk_pulses("R3", 7'h00, 0);
    chk("R3", "load_addr kept", load_addr, 0);
    run_cmd("ZCHLT");
    chk_echo("R3", "(HLT)");
    chk_pulses("R10", 7'h10, 0);
  endtask

  task automatic t_pulses;
    fn_enable = 1; sys_idle = 1;
    begin_cmd("ZCRSY");
    chk("R10", "rst_sys in cycle after CR", rst_sys, 1);
    @(negedge clk);
    chk("R10", "rst_sys one cycle", rst_sys, 0);
    end_cmd();
    chk_echo("R10", "(RSY)");
    run_cmd("ZCRBP");
    chk_echo("R10", "(RBP)");
    chk_pulses("R10", 7'h04, 0);
    run_cmd("ZCRIO");
    chk_echo("R10", "(RIO)");
    chk_pulses("R10", 7'h08, 0);
    run_cmd("ZCRUN");
    chk_echo("R10", "(RUN)");
    chk_pulses("R10", 7'h20, 0);
  endtask

  task automatic t_load;
    fn_enable = 1; sys_idle = 1;
    begin_cmd("ZCLDN1F3C");
    chk("R9", "load_start pulse", load_start, 1);
    chk("R9", "load_addr", load_addr, 16'h1F3C);
    end_cmd();
    chk_echo("R9", "(LDN@1F3C)");
    chk_pulses("R9", 7'h40, 0);
    run_cmd("ZCLDN12G4");
    chk_echo("R11", "(ERR)");
    chk("R11", "load_addr after bad hex", load_addr, 16'h1F3C);
    run_cmd("ZCLDN12345");
    chk_echo("R11", "(ERR)");
    chk_pulses("R11", 7'h00, 0);
  endtask

  task automatic t_errors;
    run_cmd("ZCSSG");
    chk_echo("R11", "(ERR)");
    chk("R11", "sense after bad digit", sense_sw, 4'h9);
    chk_pulses("R11", 7'h00, 0);
    run_cmd("ZDSSW");
    chk_echo("R11", "(ERR)");
    run_cmd("ZCXYZ");
    chk_echo("R11", "(ERR)");
    run_cmd("");
    chk_echo("R11", "(ERR)");
    run_cmd("ZCSSW");
    chk_echo("R11", "(SSW=1001)");
  endtask

  task automatic t_super_reset;
    @(negedge clk);
    super_reset = 1; cpu_sw_we = 1; cpu_sw_wdata = 4'h5;
    @(negedge clk);
    super_reset = 0; cpu_sw_we = 0;
    chk("R8", "super reset clears", sense_sw, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_set_switches();
    t_read_backpressure();
    t_cpu_arbitration();
    t_interrupt();
    t_gating();
    t_pulses();
    t_load();
    t_errors();
    t_super_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: got hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule